// File: doc/BRIEF.md
# Segmented ROM Bank Mapper

This block sits between a CPU with a 20-bit address bus and three memory targets: the internal work RAM, the cartridge battery SRAM and the cartridge ROM. The top four address bits pick one of sixteen 64 KB windows. The two lowest windows go straight to RAM and to SRAM. Every other window is steered into the ROM through a bank number.

Window 2 and window 3 each take their bank from a private 8-bit register. The twelve windows from 4 to 15 share one base register. Their bank number is built from the low nibble of that base, which becomes the high nibble of the bank, with the window index as the low nibble. The bank number is trimmed to the fitted ROM size before it is joined to the 16-bit offset. A bank value of all ones therefore always lands on the final 64 KB of whatever ROM is fitted.

Configuration writes are registered. Address translation is purely combinational, so an access made in the same cycle as a write still sees the previous mapping.

Top module: `seg_map_top`

## Requirements
- R1: When `cpu_addr[19:16]` is 0, only `ram_cs` is high and `rom_addr` is zero.
- R2: When `cpu_addr[19:16]` is 1, only `sram_cs` is high and `rom_addr` is zero.
- R3: For windows 2 to 15, only `rom_cs` is high and `rom_addr[15:0]` equals `cpu_addr[15:0]`.
- R4: In window 2, `rom_addr[23:16]` is the window-2 bank register (select code 0), after the size mask.
- R5: In window 3, `rom_addr[23:16]` is the window-3 bank register (select code 1), which is independent of the window-2 register. The size mask is applied.
- R6: In windows 4 to 15, the unmasked bank is {base[3:0], window index}, where base is the shared register at select code 2. For example, a base of 0x4E in window 9 gives bank 0xE9.
- R7: The bank is ANDed with a mask of (8 << `rom_size`) - 1 for `rom_size` 0 to 4, which covers 4, 8, 16, 32 and 64 Mbit. For `rom_size` 5 to 7 (128 Mbit) the mask is 0xFF.
- R8: After reset, both private bank registers and the base register read 0xFF. Window 2, window 3 and window 15 therefore select bank 0xFF, and window 4 selects 0xF4.
- R9: A write with `cfg_we` high lands on the next rising clock edge. An access in the same cycle still uses the old mapping.
- R10: `cfg_rdata` combinationally returns the full 8 bits last written to the register named by `cfg_sel`. This includes base bits 7:4, which translation does not use.
- R11: Select code 3 names no register. It reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 window-2 bank, 1 window-3 bank, 2 shared base, 3 none |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| rom_size | input | 3 | Fitted ROM size code, 0 = 4 Mbit up to 5 = 128 Mbit |
| cpu_addr | input | 20 | CPU address |
| ram_cs | output | 1 | Internal RAM select |
| sram_cs | output | 1 | Cartridge SRAM select |
| rom_cs | output | 1 | Cartridge ROM select |
| rom_addr | output | 24 | Physical ROM address {bank, offset} |

## Verification
The in-RTL properties assume that `cpu_addr`, `rom_size` and the configuration inputs are known and settled before each rising edge. The write-visibility check also assumes that `rom_size` does not change between a write and the access that follows it. The bench changes every input only just after a rising edge and samples at the falling edge. It holds `cfg_we` low throughout reset. It only changes `rom_size` in cycles that carry no write whose effect is later checked under a different size.

// File: rtl/seg_map_pkg.sv
package seg_map_pkg;

    parameter int ADDR_W      = 20;
    parameter int SEG_W       = 4;
    parameter int BANK_W      = 8;
    parameter int SIZE_W      = 3;
    parameter int MIN_BANK_LG = 3;
    localparam int OFF_W      = ADDR_W - SEG_W;
    localparam int BASE_W     = BANK_W - SEG_W;
    localparam int PHYS_W     = BANK_W + OFF_W;

    typedef enum logic [1:0] {
        SEL_BANK2 = 2'd0,
        SEL_BANK3 = 2'd1,
        SEL_BASE  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank2;
        logic [BANK_W-1:0] bank3;
        logic [BANK_W-1:0] base;
    } bank_regs_t;

    typedef struct packed {
        logic ram;
        logic sram;
        logic rom;
    } tgt_sel_t;

endpackage

// File: rtl/seg_map_regs.sv
module seg_map_regs
    import seg_map_pkg::*;
#(
    parameter logic [BANK_W-1:0] RESET_BANK = '1,
    parameter logic [BANK_W-1:0] RESET_BASE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [BANK_W-1:0] wr_data,
    output bank_regs_t        regs,
    output logic [BANK_W-1:0] rd_data
);

    bank_regs_t st_d, st_q;

    // Next-state: only the addressed register changes; SEL_NONE is inert (R11)
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_BANK2: st_d.bank2 = wr_data;
                SEL_BANK3: st_d.bank3 = wr_data;
                SEL_BASE:  st_d.base  = wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bank2 <= RESET_BANK;
            st_q.bank3 <= RESET_BANK;
            st_q.base  <= RESET_BASE;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs = st_q;

    // Read port returns stored value in full (R10)
    always_comb begin
        case (wr_sel)
            SEL_BANK2: rd_data = st_q.bank2;
            SEL_BANK3: rd_data = st_q.bank3;
            SEL_BASE:  rd_data = st_q.base;
            default:   rd_data = '0;
        endcase
    end

    a_r11_none_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel == SEL_NONE) |-> (rd_data == '0));

    a_r11_none_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_NONE) |=> (regs == $past(regs)));

endmodule

// File: rtl/seg_map_mask.sv
module seg_map_mask
    import seg_map_pkg::*;
(
    input  logic [SIZE_W-1:0] size_code,
    output logic [BANK_W-1:0] bank_mask
);

    localparam int LIMIT_W = SIZE_W + 2;

    logic [LIMIT_W-1:0] bank_bits;

    assign bank_bits = LIMIT_W'(size_code) + LIMIT_W'(MIN_BANK_LG);

    // One comparator per bank bit: bit kept while below the fitted bank count
    for (genvar i = 0; i < BANK_W; i++) begin : g_mask_bit
        assign bank_mask[i] = (LIMIT_W'(i) < bank_bits);
    end

endmodule

// File: rtl/seg_map_xlate.sv
module seg_map_xlate
    import seg_map_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  bank_regs_t        regs,
    input  logic [BANK_W-1:0] bank_mask,
    output tgt_sel_t          tgt,
    output logic [PHYS_W-1:0] phys_addr
);

    localparam logic [SEG_W-1:0] SEG_RAM  = SEG_W'(0);
    localparam logic [SEG_W-1:0] SEG_SRAM = SEG_W'(1);
    localparam logic [SEG_W-1:0] SEG_B2   = SEG_W'(2);
    localparam logic [SEG_W-1:0] SEG_B3   = SEG_W'(3);

    logic [SEG_W-1:0]  seg_idx;
    logic [OFF_W-1:0]  offset;
    logic [BANK_W-1:0] raw_bank;

    assign seg_idx = addr[ADDR_W-1:OFF_W];
    assign offset  = addr[OFF_W-1:0];

    always_comb begin
        tgt      = '0;
        raw_bank = '0;
        case (seg_idx)
            SEG_RAM:  tgt.ram  = 1'b1;
            SEG_SRAM: tgt.sram = 1'b1;
            SEG_B2: begin
                tgt.rom  = 1'b1;
                raw_bank = regs.bank2;
            end
            SEG_B3: begin
                tgt.rom  = 1'b1;
                raw_bank = regs.bank3;
            end
            default: begin
                tgt.rom  = 1'b1;
                raw_bank = {regs.base[BASE_W-1:0], seg_idx};
            end
        endcase
    end

    assign phys_addr = tgt.rom ? {raw_bank & bank_mask, offset} : '0;

endmodule

// File: rtl/seg_map_top.sv
module seg_map_top
    import seg_map_pkg::*;
#(
    parameter logic [BANK_W-1:0] RESET_BANK = '1,
    parameter logic [BANK_W-1:0] RESET_BASE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [BANK_W-1:0] cfg_wdata,
    output logic [BANK_W-1:0] cfg_rdata,
    input  logic [SIZE_W-1:0] rom_size,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              ram_cs,
    output logic              sram_cs,
    output logic              rom_cs,
    output logic [PHYS_W-1:0] rom_addr
);

    bank_regs_t        regs;
    logic [BANK_W-1:0] bank_mask;
    tgt_sel_t          tgt;

    seg_map_regs #(
        .RESET_BANK (RESET_BANK),
        .RESET_BASE (RESET_BASE)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (reg_sel_e'(cfg_sel)),
        .wr_data (cfg_wdata),
        .regs    (regs),
        .rd_data (cfg_rdata)
    );

    seg_map_mask i_mask (
        .size_code (rom_size),
        .bank_mask (bank_mask)
    );

    seg_map_xlate i_xlate (
        .addr      (cpu_addr),
        .regs      (regs),
        .bank_mask (bank_mask),
        .tgt       (tgt),
        .phys_addr (rom_addr)
    );

    assign ram_cs  = tgt.ram;
    assign sram_cs = tgt.sram;
    assign rom_cs  = tgt.rom;

    // R1/R2/R3: exactly one target per access
    a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({ram_cs, sram_cs, rom_cs}));

    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> (rom_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]));

    // R4/R9: a window-2 write is visible on the following cycle
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we) && $past(cfg_sel) == 2'd0
         && $stable(rom_size) && cpu_addr[ADDR_W-1:OFF_W] == SEG_W'(2))
        |-> (rom_addr[PHYS_W-1:OFF_W] == ($past(cfg_wdata) & bank_mask)));

    // R6: upper bank nibble of shared windows tracks the base read port
    a_r6_base_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == 2'd2 && cpu_addr[ADDR_W-1:OFF_W] >= SEG_W'(4))
        |-> (rom_addr[PHYS_W-1:PHYS_W-BASE_W]
             == (cfg_rdata[BASE_W-1:0] & bank_mask[BANK_W-1:SEG_W])));

    // R7: no bank bit above the fitted size
    a_r7_size_trim: assert property (@(posedge clk) disable iff (!rst_n)
        ((rom_addr[PHYS_W-1:OFF_W] >> ({1'b0, rom_size} + 4'd3)) == '0));

endmodule

// File: tb/test_seg_map_top.sv
module test_seg_map_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic [7:0]  cfg_rdata;
    logic [2:0]  rom_size = 3'd5;
    logic [19:0] cpu_addr = 20'd0;
    logic        ram_cs, sram_cs, rom_cs;
    logic [23:0] rom_addr;

    always #2.5 clk = ~clk;

    seg_map_top i_seg_map_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rom_size(rom_size),
        .cpu_addr(cpu_addr), .ram_cs(ram_cs), .sram_cs(sram_cs),
        .rom_cs(rom_cs), .rom_addr(rom_addr)
    );

    typedef struct packed {
        logic [2:0]  cs;
        logic [23:0] phys;
        logic [7:0]  rd;
        logic [7:0]  req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    logic [7:0] sh_b2 = 8'hFF, sh_b3 = 8'hFF, sh_base = 8'hFF;

    function automatic logic [7:0] size_mask(input logic [2:0] sz);
        if (sz >= 3'd5) return 8'hFF;
        return (8'd8 << sz) - 8'd1;
    endfunction

    // Driver: apply one access (optionally with a write) and push expectation
    task automatic drive(input logic [19:0] a, input logic we, input logic [1:0] sel,
                         input logic [7:0] wd, input logic [2:0] sz, input int req);
        exp_t e;
        logic [3:0] seg;
        logic [7:0] bank;
        @(posedge clk);
        #1;
        cpu_addr = a; cfg_we = we; cfg_sel = sel; cfg_wdata = wd; rom_size = sz;
        seg = a[19:16];
        bank = (seg == 4'd2) ? sh_b2 : (seg == 4'd3) ? sh_b3 : {sh_base[3:0], seg};
        e.cs   = (seg == 4'd0) ? 3'b100 : (seg == 4'd1) ? 3'b010 : 3'b001;
        e.phys = (seg < 4'd2) ? 24'd0 : {bank & size_mask(sz), a[15:0]};
        e.rd   = (sel == 2'd0) ? sh_b2 : (sel == 2'd1) ? sh_b3 : (sel == 2'd2) ? sh_base : 8'h00;
        e.req  = 8'(req);
        exp_q.push_back(e);
        if (we) begin
            if (sel == 2'd0) sh_b2 = wd;
            else if (sel == 2'd1) sh_b3 = wd;
            else if (sel == 2'd2) sh_base = wd;
        end
    endtask

    // Monitor: compares at the falling edge
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks += 3;
            if ({ram_cs, sram_cs, rom_cs} !== e.cs) begin
                failures++;
                $display("FAIL R%0d selects actual=%b expected=%b", e.req, {ram_cs, sram_cs, rom_cs}, e.cs);
            end
            if (rom_addr !== e.phys) begin
                failures++;
                $display("FAIL R%0d rom_addr actual=%h expected=%h", e.req, rom_addr, e.phys);
            end
            if (cfg_rdata !== e.rd) begin
                failures++;
                $display("FAIL R%0d rdata actual=%h expected=%h", e.req, cfg_rdata, e.rd);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [19:0] lf;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R8: reset mapping and readback
        drive(20'h2_1234, 0, 2'd0, 8'h00, 3'd5, 8);
        drive(20'h3_0000, 0, 2'd1, 8'h00, 3'd5, 8);
        drive(20'h4_FFFF, 0, 2'd2, 8'h00, 3'd5, 8);
        drive(20'hF_8001, 0, 2'd2, 8'h00, 3'd5, 8);
        // R1, R2: RAM and SRAM windows
        drive(20'h0_ABCD, 0, 2'd0, 8'h00, 3'd5, 1);
        drive(20'h1_5555, 0, 2'd1, 8'h00, 3'd5, 2);
        // R9: write with same-cycle access sees old bank; R4 next cycle
        drive(20'h2_0010, 1, 2'd0, 8'h12, 3'd5, 9);
        drive(20'h2_0010, 0, 2'd0, 8'h00, 3'd5, 4);
        // R5: window 3 independent of window 2
        drive(20'h3_0020, 1, 2'd1, 8'h34, 3'd5, 9);
        drive(20'h3_0020, 0, 2'd1, 8'h00, 3'd5, 5);
        drive(20'h2_0020, 0, 2'd0, 8'h00, 3'd5, 5);
        // R6 + R10: base 0x4E maps window 9 to E9; full byte reads back
        drive(20'h9_0000, 1, 2'd2, 8'h4E, 3'd5, 6);
        drive(20'h9_0042, 0, 2'd2, 8'h00, 3'd5, 10);
        for (int s = 4; s < 16; s++) drive({4'(s), 16'h0100}, 0, 2'd2, 8'h00, 3'd5, 6);
        // R7: every size code on windows 2, 9 and 15
        for (int z = 0; z < 8; z++) begin
            drive(20'h2_0000, 0, 2'd0, 8'h00, 3'(z), 7);
            drive(20'h9_0001, 0, 2'd2, 8'h00, 3'(z), 7);
            drive(20'hF_0002, 0, 2'd1, 8'h00, 3'(z), 7);
        end
        // R11: select 3 reads zero, write leaves all registers alone
        drive(20'h2_0000, 1, 2'd3, 8'h55, 3'd5, 11);
        drive(20'h2_0000, 0, 2'd0, 8'h00, 3'd5, 11);
        drive(20'h3_0000, 0, 2'd1, 8'h00, 3'd5, 11);
        drive(20'hA_0000, 0, 2'd2, 8'h00, 3'd5, 11);
        // R3: offset passthrough across varied addresses
        lf = 20'h5A3C1;
        for (int k = 0; k < 40; k++) begin
            lf = {lf[18:0], lf[19] ^ lf[16]};
            drive(lf, 0, 2'(k % 4), 8'h00, 3'(k % 6), 3);
        end
        // R9: back-to-back base writes
        drive(20'hC_0000, 1, 2'd2, 8'hA7, 3'd5, 9);
        drive(20'hC_0000, 1, 2'd2, 8'h03, 3'd5, 9);
        drive(20'hC_0000, 0, 2'd2, 8'h00, 3'd5, 9);
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule